// File: doc/BRIEF.md
# PWM Fault Trip and Resynchronisation Controller

This block sits beside a bank of PWM channels and guards them against an external fault. A single fault pin is brought into the bus clock domain, qualified, and compared against a programmed polarity. Once a fault is recognised, every enabled channel output is replaced by a programmed safe level until software asks for a restart and each channel has reached its own counter-zero point. The duty generators and counters live outside; this block only sees their waveforms, their enables and their counter-zero strobes.

Software controls it through one 8-bit register on a simple write-strobe port with combinational read data. The layout, from bit 7 down to bit 0, is: change flag, interrupt enable, restart (write-only strobe), safe level, reserved, synchronised pin level (read-only), fault polarity, trip enable. An interrupt line is raised while the change flag and the interrupt enable are both set.

The sequencing is a three-state machine. `ST_RUN` (normal running) moves to `ST_TRIP` on a recognised fault. `ST_TRIP` (all channels held) moves to `ST_RESYNC` either on a restart write while the qualified pin is not at its active level, or when trip enable is cleared. `ST_RESYNC` (channels released one by one at counter zero) moves back to `ST_TRIP` if the fault is recognised again, and to `ST_RUN` once no channel is still held.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset the register reads 8'h00, `irq` is 0 and every `pwm_out` bit equals the matching `pwm_in` bit.
- R2: A fault is recognised only when the pin, after a two-flop synchroniser, has sat at its active level for two consecutive clocks; a pin pulse of one clock period causes no trip and no flag, and a pulse of two or more clock periods trips the block.
- R3: Register bit 1 selects the fault polarity: 1 makes a high pin active, 0 makes a low pin active.
- R4: While channels are held, each channel whose `ch_en` bit is 1 drives register bit 4 (all 0 or all 1), and each channel whose `ch_en` bit is 0 passes `pwm_in` through.
- R5: Register bit 7 sets on every change of the recognised fault, rising or falling, while trip enable is 1; writing 1 to bit 7 clears it, and writing 0 to bit 7 leaves it set.
- R6: `irq` is 1 exactly when register bit 7 and register bit 6 are both 1.
- R7: A restart (write with bit 5 = 1) made while the qualified pin is at its active level is ignored: all enabled channels stay at the safe level even when counter-zero strobes arrive.
- R8: After an accepted restart, each channel leaves the safe level only in the cycle after its own `cnt_zero` bit was 1; channels whose strobe has not come stay held.
- R9: Bit 5 (restart) and bit 3 (reserved) always read 0 regardless of what is written.
- R10: Register bit 2 shows the fault pin level delayed by two clocks, whether or not trip enable is set.
- R11: With register bit 0 (trip enable) at 0 no fault trips the block; clearing it while channels are held starts the release, and channels still wait for their counter-zero strobe.
- R12: If the fault is recognised again during the release, all channels, including those already released, return to the safe level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| fault_pin | input | 1 | Raw asynchronous fault pin |
| pwm_in | input | NCH | Waveforms from the channel generators |
| ch_en | input | NCH | Channel enables |
| cnt_zero | input | NCH | Per-channel strobe, 1 when that channel's counter passes zero |
| pwm_out | output | NCH | Channel outputs after the shutdown override |
| irq | output | 1 | Interrupt request |

## Verification
Fault pulses of one to four clock periods are applied at random lengths with a fixed seed; whether the outputs go to the safe level and the flag sets separates a correct two-cycle qualifier from one that is too eager or too slow. While held, random waveform and enable patterns show that only enabled channels are overridden. Staggered counter-zero strobes after a restart tell per-channel release apart from a global one, and a fault that returns mid-release, a restart attempted during the fault, and trip enable cleared during a hold each exercise a separate transition of the state machine. Both polarities and both safe levels are used so that a stuck polarity or level is exposed.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_TRIP   = 2'd1,
        ST_RESYNC = 2'd2
    } sd_state_t;

    // Bit positions in the control/status register
    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_RST  = 5;
    localparam int B_LVL  = 4;
    localparam int B_PIN  = 2;
    localparam int B_POL  = 1;
    localparam int B_EN   = 0;

endpackage

// File: rtl/pwm_sd_qual.sv
module pwm_sd_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic enable,
    input  logic act_high,
    output logic pin_sync,
    output logic active,
    output logic fault
);

    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);
    localparam logic [CW-1:0] QHIT = CW'(QUAL_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sh_q;
    logic [CW-1:0]          cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-2:0], pin};
        end
    end

    assign pin_sync = sh_q[SYNC_STAGES-1];
    assign active   = enable && (pin_sync == act_high);

    // Count consecutive active cycles, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (cnt_q != QMAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fault = active && (cnt_q >= QHIT);

endmodule

// File: rtl/pwm_sd_chan.sv
module pwm_sd_chan #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trip_all,
    input  logic           release_en,
    input  logic [NCH-1:0] cnt_zero,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] pwm_in,
    input  logic           safe_lvl,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] hold,
    output logic           hold_any
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (trip_all) begin
                    hold[i] <= 1'b1;
                end else if (release_en && cnt_zero[i]) begin
                    hold[i] <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_mux
        assign pwm_out[g] = (hold[g] && ch_en[g]) ? safe_lvl : pwm_in[g];
    end

    assign hold_any = |hold;

endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import pwm_sd_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic           fault_pin,
    input  logic [NCH-1:0] pwm_in,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] cnt_zero,
    output logic [NCH-1:0] pwm_out,
    output logic           irq
);

    sd_state_t state_q, state_d;

    logic flag_q, ie_q, lvl_q, pol_q, en_q;
    logic pin_sync, active, fault_now, fault_d;
    logic trip_all, release_en, hold_any;
    logic [NCH-1:0] hold;
    logic restart_req, flag_set, flag_clr;

    pwm_sd_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (fault_pin),
        .enable   (en_q),
        .act_high (pol_q),
        .pin_sync (pin_sync),
        .active   (active),
        .fault    (fault_now)
    );

    pwm_sd_chan #(
        .NCH (NCH)
    ) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_all   (trip_all),
        .release_en (release_en),
        .cnt_zero   (cnt_zero),
        .ch_en      (ch_en),
        .pwm_in     (pwm_in),
        .safe_lvl   (lvl_q),
        .pwm_out    (pwm_out),
        .hold       (hold),
        .hold_any   (hold_any)
    );

    // Register bank
    assign restart_req = reg_wr && reg_wdata[B_RST];
    assign flag_set    = en_q && (fault_now ^ fault_d);
    assign flag_clr    = reg_wr && reg_wdata[B_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            lvl_q   <= 1'b0;
            pol_q   <= 1'b0;
            en_q    <= 1'b0;
            flag_q  <= 1'b0;
            fault_d <= 1'b0;
        end else begin
            fault_d <= fault_now;
            flag_q  <= flag_set || (flag_q && !flag_clr);
            if (reg_wr) begin
                ie_q  <= reg_wdata[B_IE];
                lvl_q <= reg_wdata[B_LVL];
                pol_q <= reg_wdata[B_POL];
                en_q  <= reg_wdata[B_EN];
            end
        end
    end

    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_FLAG] = flag_q;
        reg_rdata[B_IE]   = ie_q;
        reg_rdata[B_LVL]  = lvl_q;
        reg_rdata[B_PIN]  = pin_sync;
        reg_rdata[B_POL]  = pol_q;
        reg_rdata[B_EN]   = en_q;
    end

    assign irq = flag_q && ie_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fault_now) state_d = ST_TRIP;
            end
            ST_TRIP: begin
                if (!en_q)                         state_d = ST_RESYNC;
                else if (restart_req && !active)   state_d = ST_RESYNC;
            end
            ST_RESYNC: begin
                if (fault_now)      state_d = ST_TRIP;
                else if (!hold_any) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State outputs
    always_comb begin
        trip_all   = 1'b0;
        release_en = 1'b0;
        unique case (state_q)
            ST_RUN:    trip_all   = fault_now;
            ST_TRIP:   trip_all   = 1'b0;
            ST_RESYNC: begin
                trip_all   = fault_now;
                release_en = !fault_now;
            end
            default: begin
                trip_all   = 1'b0;
                release_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwm_sd_chk.sv
module pwm_sd_chk
    import pwm_sd_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input sd_state_t      state,
    input logic [NCH-1:0] hold,
    input logic [NCH-1:0] cnt_zero,
    input logic [NCH-1:0] pwm_out,
    input logic [NCH-1:0] ch_en,
    input logic           lvl,
    input logic           en,
    input logic           active,
    input logic           fault_now
);

    AST_FAULT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_now |=> (state == ST_TRIP));  // R2

    AST_TRIP_FORCES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP) |-> (((pwm_out ^ {NCH{lvl}}) & ch_en) == '0));  // R4

    AST_RESTART_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && en && active) |=> (state == ST_TRIP));  // R7

    AST_RELEASE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hold) & ~hold & ~$past(cnt_zero)) == '0));  // R8

    AST_DISABLED_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && state != ST_TRIP) |=> (state != ST_TRIP));  // R11

endmodule

bind pwm_trip_guard pwm_sd_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .hold      (hold),
    .cnt_zero  (cnt_zero),
    .pwm_out   (pwm_out),
    .ch_en     (ch_en),
    .lvl       (lvl_q),
    .en        (en_q),
    .active    (active),
    .fault_now (fault_now)
);

// File: tb/sim_pwm_trip_guard.sv
module sim_pwm_trip_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           reg_wr;
    logic [7:0]     reg_wdata;
    logic [7:0]     reg_rdata;
    logic           fault_pin;
    logic [NCH-1:0] pwm_in;
    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] cnt_zero;
    logic [NCH-1:0] pwm_out;
    logic           irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_trip_guard #(.NCH(NCH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fault_pin (fault_pin),
        .pwm_in    (pwm_in),
        .ch_en     (ch_en),
        .cnt_zero  (cnt_zero),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    function automatic logic [NCH-1:0] exp_out(input logic [NCH-1:0] din,
                                               input logic [NCH-1:0] en,
                                               input logic [NCH-1:0] held,
                                               input logic           lvl);
        logic [NCH-1:0] m;
        m = held & en;
        return (din & ~m) | ({NCH{lvl}} & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        reg_wr    = 1'b1;
        reg_wdata = b;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic zero_pulse(input logic [NCH-1:0] m);
        cnt_zero = m;
        @(negedge clk);
        cnt_zero = '0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; fault_pin = 1'b0;
        pwm_in = 8'hA5; ch_en = 8'hFF; cnt_zero = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 pass", pwm_out, 8'hA5);

        // R10 pin status, R11 no trip while disabled
        fault_pin = 1'b1;
        cyc(2);
        chk("R10 pin status", reg_rdata[2], 1);
        cyc(4);
        chk("R11 disabled no trip", pwm_out, 8'hA5);
        fault_pin = 1'b0;
        cyc(3);
        chk("R10 pin low", reg_rdata[2], 0);

        // R4/R5 trip, active high, level 0
        wr(8'h03);
        ch_en = 8'h0F;
        fault_pin = 1'b1;
        cyc(4);
        chk("R4 forced low", pwm_out, exp_out(8'hA5, 8'h0F, '1, 1'b0));
        chk("R5 flag on trip", reg_rdata[7], 1);
        chk("R6 irq masked", irq, 0);

        // R4 random patterns while held
        for (int k = 0; k < 16; k++) begin
            pwm_in = NCH'($urandom);
            ch_en  = NCH'($urandom);
            #1;
            chk("R4 random held", pwm_out, exp_out(pwm_in, ch_en, '1, 1'b0));
            cyc(1);
        end

        // R7 restart during active fault ignored
        ch_en = 8'hFF; pwm_in = 8'hFF;
        wr(8'h23);
        zero_pulse('1);
        cyc(2);
        chk("R7 restart blocked", pwm_out, 8'h00);

        // R5 write 0 keeps flag, write 1 clears
        fault_pin = 1'b0;
        cyc(5);
        wr(8'h03);
        chk("R5 write0 keeps", reg_rdata[7], 1);
        wr(8'h83);
        chk("R5 write1 clears", reg_rdata[7], 0);
        chk("R8 held before restart", pwm_out, 8'h00);

        // R9 restart and reserved read 0; R8 per-channel release
        wr(8'h2B);
        chk("R9 readback", reg_rdata, 8'h03);
        zero_pulse(8'h01);
        chk("R8 ch0 released", pwm_out, 8'h01);
        cyc(3);
        chk("R8 others held", pwm_out, 8'h01);
        zero_pulse(8'hFE);
        chk("R8 all released", pwm_out, 8'hFF);
        cyc(1);

        // R3 active low, level 1, R6 irq
        pwm_in = 8'h00;
        wr(8'h51);
        cyc(3);
        chk("R3 active low trip", pwm_out, 8'hFF);
        chk("R5 flag set", reg_rdata[7], 1);
        chk("R6 irq on", irq, 1);
        fault_pin = 1'b1;
        cyc(5);
        wr(8'hD1);
        chk("R6 irq off", irq, 0);
        chk("R5 cleared", reg_rdata[7], 0);

        // R11 disable while held
        fault_pin = 1'b0;
        cyc(5);
        chk("R11 tripped", pwm_out, 8'hFF);
        wr(8'h50);
        cyc(3);
        chk("R11 still held", pwm_out, 8'hFF);
        zero_pulse('1);
        chk("R11 released at zero", pwm_out, 8'h00);
        cyc(5);
        chk("R11 disabled no retrip", pwm_out, 8'h00);

        // R12 fault returns during release
        wr(8'hD3);
        fault_pin = 1'b1;
        cyc(4);
        chk("R12 trip", pwm_out, 8'hFF);
        fault_pin = 1'b0;
        cyc(4);
        wr(8'h33);
        zero_pulse(8'h0F);
        chk("R12 partial release", pwm_out, 8'hF0);
        fault_pin = 1'b1;
        cyc(4);
        chk("R12 retrip all", pwm_out, 8'hFF);
        fault_pin = 1'b0;
        cyc(4);
        wr(8'h33);
        zero_pulse('1);
        chk("R12 recovered", pwm_out, 8'h00);
        wr(8'h93);
        chk("R9 rdata", reg_rdata, 8'h13);

        // R2 pulse-length qualification
        for (int k = 0; k < 12; k++) begin
            int len;
            logic hit;
            len = (k < 4) ? k + 1 : int'($urandom_range(1, 4));
            hit = (len >= 2);
            fault_pin = 1'b1;
            cyc(len);
            fault_pin = 1'b0;
            cyc(6);
            chk("R2 pulse out", pwm_out, hit ? 8'hFF : 8'h00);
            chk("R2 pulse flag", reg_rdata[7], hit);
            wr(8'h33);
            zero_pulse('1);
            wr(8'h93);
            cyc(1);
        end

        done = 1'b1;
        report();
    end

endmodule